// File: doc/BRIEF.md
# Serial Frequency Step Command Interface

This block lets a host nudge a square-wave generator's period over a plain asynchronous serial line. It receives 8N1 characters and recognises three of them as step commands. A step moves a divider value by one count: the key that raises the output frequency lowers the divider, and the key that lowers the frequency raises it. Each change is presented to the generator as the new value plus a single-cycle load strobe. The generator consumes that strobe as a deferred load, which takes effect at the end of its current output period and never truncates it, so the waveform stays continuous while it is tuned.

After every recognised command, the block sends the divider value back over its own serial transmitter as decimal text. This happens even when the command was refused because the value already sits at the edge of its allowed window. While a report is being sent, one further command is held and run after the report ends. Any other command that arrives in that time is lost. There is no back-pressure on the receive side: the serial line cannot be stalled, so extra bytes are dropped, not delayed. The transmit path inside the block is a valid/ready stream from the report formatter into the transmitter. The formatter holds each character until the transmitter accepts it.

With the default parameters, the block assumes a 100 MHz clock and a 75 MHz generator source divided by six times (divider + 1). The reset value of 2499 then gives 5000 Hz, and one count is roughly 2 Hz.

Top module: `freq_step_uart`

## Requirements
- R1: After reset the divider output equals DIV_RESET, the load strobe is low and the serial output idles high.
- R2: Both serial directions use 8N1 framing: a low start bit, eight data bits LSB first and a high stop bit. Each bit lasts CLKS_PER_BIT clocks, and the default of 868 at 100 MHz is close to 115,200 baud.
- R3: A received '-' (0x2D) raises the divider by one count, which lowers the output frequency.
- R4: A received '+' (0x2B) or '=' (0x3D) lowers the divider by one count, which raises the output frequency.
- R5: The divider output changes only in a cycle where the load strobe is high. That strobe lasts exactly one cycle, and each load moves the value by exactly one count.
- R6: The divider never leaves the window [DIV_MIN, DIV_MAX]. A command that would leave it causes no load strobe and no change, but it still produces a report.
- R7: Each recognised command produces one report: five ASCII decimal digits of the divider value after the command, most significant digit first, then 0x0D and 0x0A.
- R8: Any other byte value, and any byte whose stop bit samples low, is discarded. It produces no report and no change.
- R9: A command that arrives while a report is still in flight (formatter or transmitter busy) is held in a single slot and run once the line is idle. Further commands that arrive while the slot is full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| div_value_o | output | DIV_W | Current divider value for the generator |
| div_load_o | output | 1 | One-cycle strobe: apply div_value_o at the end of the current period |

## Verification
The bench walks the divider into both edges of its window and presses past each edge once more. A design that clamped wrongly would step outside the window, or would skip the report for a refused command. It sends the two aliases of the raise key separately, so a decoder that knew only one of them would leave the value unchanged and send no text. It also sends a printable non-command byte and a byte with a low stop bit; a design that leaked either would emit text or move the value. Three commands sent back to back exercise the single-slot hold. If the slot were missing, only one report would come back. If it were deeper than one, a third report would appear and the value would end one count too low.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

  typedef enum logic [1:0] {
    STEP_NONE,
    STEP_FREQ_UP,    // divider - 1
    STEP_FREQ_DOWN   // divider + 1
  } step_e;

  function automatic step_e decode_cmd(input logic [7:0] b);
    case (b)
      8'h2B, 8'h3D: decode_cmd = STEP_FREQ_UP;
      8'h2D:        decode_cmd = STEP_FREQ_DOWN;
      default:      decode_cmd = STEP_NONE;
    endcase
  endfunction

  function automatic int unsigned pow10(input int n);
    int unsigned p;
    p = 1;
    for (int i = 0; i < n; i++) p = p * 10;
    return p;
  endfunction

endpackage

// File: rtl/fsu_uart_rx.sv
module fsu_uart_rx #(
  parameter int CLKS_PER_BIT = 868
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_data_o
);
  localparam int CW   = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF = CLKS_PER_BIT / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  rx_st_e       st_q;
  logic [1:0]   sync_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]   bit_q;
  logic [7:0]   sh_q;
  logic         rx_s;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= RX_IDLE;
      sync_q       <= 2'b11;
      cnt_q        <= '0;
      bit_q        <= '0;
      sh_q         <= '0;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
    end else begin
      sync_q       <= {sync_q[0], rx_i};
      byte_valid_o <= 1'b0;
      case (st_q)
        RX_IDLE: if (!rx_s) begin
          cnt_q <= '0;
          st_q  <= RX_START;
        end
        RX_START: if (cnt_q == CW'(HALF - 1)) begin
          cnt_q <= '0;
          bit_q <= '0;
          st_q  <= rx_s ? RX_IDLE : RX_DATA;
        end else cnt_q <= cnt_q + 1'b1;
        RX_DATA: if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
          cnt_q <= '0;
          sh_q  <= {rx_s, sh_q[7:1]};
          if (bit_q == 3'd7) st_q <= RX_STOP;
          else bit_q <= bit_q + 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        default: if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
          cnt_q        <= '0;
          byte_valid_o <= rx_s;   // low stop bit: framing error, dropped
          byte_data_o  <= sh_q;
          st_q         <= RX_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fsu_uart_tx.sv
module fsu_uart_tx #(
  parameter int CLKS_PER_BIT = 868
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       tx_o
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);

  logic          active_q;
  logic [9:0]    sh_q;
  logic [3:0]    left_q;
  logic [CW-1:0] cnt_q;

  assign ready_o = !active_q;
  assign tx_o    = active_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sh_q     <= '1;
      left_q   <= '0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (valid_i) begin
        active_q <= 1'b1;
        sh_q     <= {1'b1, data_i, 1'b0};
        left_q   <= 4'd10;
        cnt_q    <= '0;
      end
    end else if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
      cnt_q <= '0;
      sh_q  <= {1'b1, sh_q[9:1]};
      if (left_q == 4'd1) active_q <= 1'b0;
      else left_q <= left_q - 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fsu_step_ctrl.sv
module fsu_step_ctrl
  import fsu_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 2499,
  parameter int DIV_MIN   = 2231,
  parameter int DIV_MAX   = 2840
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_data_i,
  input  logic             busy_i,
  output logic [DIV_W-1:0] div_value_o,
  output logic             div_load_o,
  output logic             report_start_o
);
  localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

  step_e pend_dir_q, dec;
  logic  pend_q, exec, accept;

  assign dec    = decode_cmd(byte_data_i);
  assign exec   = pend_q && !busy_i && !report_start_o;
  assign accept = byte_valid_i && (dec != STEP_NONE) && (!pend_q || exec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q         <= 1'b0;
      pend_dir_q     <= STEP_NONE;
      div_value_o    <= DIV_W'(DIV_RESET);
      div_load_o     <= 1'b0;
      report_start_o <= 1'b0;
    end else begin
      div_load_o     <= 1'b0;
      report_start_o <= 1'b0;
      if (exec) begin
        report_start_o <= 1'b1;
        if (pend_dir_q == STEP_FREQ_UP && div_value_o > LO) begin
          div_value_o <= div_value_o - 1'b1;
          div_load_o  <= 1'b1;
        end else if (pend_dir_q == STEP_FREQ_DOWN && div_value_o < HI) begin
          div_value_o <= div_value_o + 1'b1;
          div_load_o  <= 1'b1;
        end
      end
      if (accept) begin
        pend_q     <= 1'b1;
        pend_dir_q <= dec;
      end else if (exec) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsu_report_fmt.sv
module fsu_report_fmt
  import fsu_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] value_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic             busy_o
);
  localparam int NDIG = 5;
  localparam int NCH  = NDIG + 2;

  logic [7:0] ch_q [NCH];
  logic [7:0] ch_n [NCH];
  logic [2:0] idx_q;
  logic       active_q;

  always_comb begin
    int unsigned v;
    v = 32'(value_i);
    for (int k = 0; k < NDIG; k++)
      ch_n[k] = 8'h30 + 8'((v / pow10(NDIG - 1 - k)) % 10);
    ch_n[NDIG]     = 8'h0D;
    ch_n[NDIG + 1] = 8'h0A;
  end

  assign tx_valid_o = active_q;
  assign tx_data_o  = ch_q[idx_q];
  assign busy_o     = active_q || !tx_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      for (int k = 0; k < NCH; k++) ch_q[k] <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      for (int k = 0; k < NCH; k++) ch_q[k] <= ch_n[k];
    end else if (active_q && tx_ready_i) begin
      if (idx_q == 3'(NCH - 1)) active_q <= 1'b0;
      else idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/freq_step_uart.sv
module freq_step_uart #(
  parameter int CLK_HZ       = 100_000_000,
  parameter int BAUD         = 115_200,
  parameter int CLKS_PER_BIT = CLK_HZ / BAUD,
  parameter int DIV_W        = 16,
  parameter int DIV_RESET    = 2499,
  parameter int DIV_MIN      = 2231,
  parameter int DIV_MAX      = 2840
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  output logic             tx_o,
  output logic [DIV_W-1:0] div_value_o,
  output logic             div_load_o
);
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       busy, rep_start;
  logic       tx_valid, tx_ready;
  logic [7:0] tx_data;

  fsu_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
    .byte_valid_o(rx_valid), .byte_data_o(rx_data)
  );

  fsu_step_ctrl #(
    .DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_valid_i(rx_valid), .byte_data_i(rx_data),
    .busy_i(busy), .div_value_o(div_value_o), .div_load_o(div_load_o),
    .report_start_o(rep_start)
  );

  fsu_report_fmt #(.DIV_W(DIV_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .start_i(rep_start), .value_i(div_value_o),
    .tx_ready_i(tx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .busy_o(busy)
  );

  fsu_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .valid_i(tx_valid), .data_i(tx_data),
    .ready_o(tx_ready), .tx_o(tx_o)
  );
endmodule

// File: rtl/fsu_checks.sv
module fsu_checks #(
  parameter int DIV_W   = 16,
  parameter int DIV_MIN = 2231,
  parameter int DIV_MAX = 2840
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_value_o,
  input logic             div_load_o
);
  p_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_value_o >= DIV_W'(DIV_MIN)) && (div_value_o <= DIV_W'(DIV_MAX)));

  p_change_needs_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_value_o) |-> div_load_o);

  p_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_load_o |-> ((div_value_o == $past(div_value_o) + 1'b1) ||
                    (div_value_o == $past(div_value_o) - 1'b1)));

  p_load_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_load_o |=> !div_load_o);
endmodule

bind freq_step_uart fsu_checks #(
  .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .div_value_o(div_value_o), .div_load_o(div_load_o)
);

// File: tb/freq_step_uart_bench.sv
`timescale 1ns/1ps
module freq_step_uart_bench;
  localparam int CPB   = 16;
  localparam int BIT   = CPB * 10;
  localparam int W     = 16;
  localparam int RSTV  = 100;
  localparam int LO    = 98;
  localparam int HI    = 102;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tx;
  logic [W-1:0] div;
  logic load;

  int checks = 0, errors = 0, loads = 0;
  int model_prev = RSTV;
  bit done = 0;
  byte unsigned got_q[$];

  always #5 clk = ~clk;

  freq_step_uart #(
    .CLKS_PER_BIT(CPB), .DIV_W(W), .DIV_RESET(RSTV), .DIV_MIN(LO), .DIV_MAX(HI)
  ) u_freq_step_uart (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx),
    .div_value_o(div), .div_load_o(load)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-clock reference: value may move only on a load, by one, inside the window (R5, R6)
  always @(negedge clk) begin
    if (rst_n) begin
      if (load) begin
        loads++;
        check((int'(div) == model_prev + 1) || (int'(div) == model_prev - 1),
              "R5 unit step", int'(div), model_prev);
        check(int'(div) >= LO && int'(div) <= HI, "R6 window", int'(div), LO);
      end else if (int'(div) != model_prev) begin
        check(0, "R5 change without load", int'(div), model_prev);
      end
      model_prev = int'(div);
    end
  end

  // Serial receiver model for tx (R2)
  initial begin
    forever begin
      byte unsigned b;
      @(negedge tx);
      #(BIT / 2 + 3);
      for (int i = 0; i < 8; i++) begin
        #(BIT);
        b[i] = tx;
      end
      #(BIT);
      check(tx == 1'b1, "R2 stop bit", tx, 1);
      got_q.push_back(b);
    end
  end

  task automatic send(input byte unsigned b, input bit stop);
    @(negedge clk);
    rx = 1'b0; #(BIT);
    for (int i = 0; i < 8; i++) begin
      rx = b[i]; #(BIT);
    end
    rx = stop; #(BIT);
    rx = 1'b1; #(BIT);
  endtask

  task automatic expect_report(input int val, input string req);
    int n;
    n = 0;
    while (got_q.size() < 7 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(got_q.size() >= 7, {req, " report length"}, got_q.size(), 7);
    if (got_q.size() >= 7) begin
      int v;
      v = val;
      for (int k = 4; k >= 0; k--) begin
        byte unsigned e;
        e = 8'h30 + 8'(v / (10 ** k));
        v = v % (10 ** k);
        check(got_q[4 - k] == e, {req, " R7 digit"}, got_q[4 - k], e);
      end
      check(got_q[5] == 8'h0D, {req, " R7 CR"}, got_q[5], 13);
      check(got_q[6] == 8'h0A, {req, " R7 LF"}, got_q[6], 10);
      repeat (7) void'(got_q.pop_front());
    end
    check(int'(div) == val, {req, " value"}, int'(div), val);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(1_500_000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int l0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(int'(div) == RSTV, "R1 reset value", int'(div), RSTV);
    check(tx == 1'b1, "R1 tx idle", tx, 1);
    check(load == 1'b0, "R1 no load", load, 0);

    send(8'h2B, 1); expect_report(99, "R4 plus");
    send(8'h3D, 1); expect_report(98, "R4 equals");
    l0 = loads;
    send(8'h3D, 1); expect_report(98, "R6 low clamp");
    check(loads == l0, "R6 no load at low edge", loads, l0);
    send(8'h2D, 1); expect_report(99, "R3 minus");
    send(8'h2D, 1); expect_report(100, "R3 minus");
    send(8'h2D, 1); expect_report(101, "R3 minus");
    send(8'h2D, 1); expect_report(102, "R3 minus");
    l0 = loads;
    send(8'h2D, 1); expect_report(102, "R6 high clamp");
    check(loads == l0, "R6 no load at high edge", loads, l0);

    // R8: unknown byte and framing error
    l0 = loads;
    send(8'h61, 1);
    send(8'h2B, 0);
    repeat (3000) @(negedge clk);
    check(got_q.size() == 0, "R8 no report", got_q.size(), 0);
    check(int'(div) == 102, "R8 value unchanged", int'(div), 102);
    check(loads == l0, "R8 no load", loads, l0);

    // R9: three back-to-back commands: one runs, one held, one dropped
    send(8'h2B, 1);
    send(8'h2B, 1);
    send(8'h2B, 1);
    expect_report(101, "R9 first");
    expect_report(100, "R9 held");
    repeat (3000) @(negedge clk);
    check(got_q.size() == 0, "R9 third dropped", got_q.size(), 0);
    check(int'(div) == 100, "R9 final value", int'(div), 100);

    finish_run();
  end
endmodule